// File: doc/BRIEF.md
# Boot-time ROM signature scanner and identifier patcher

This block sits between a processor, its program ROM and a multi-image flash. When system reset is released it keeps the processor in reset and drives the ROM address bus itself. It reads the selected ROM image one byte per clock, starting at address zero and moving upward. It looks for a seven-byte marker whose third and fourth bytes are free. Those two free bytes hold the processor address of an identifier word. The block records that address, hands the ROM bus back to the processor and then lets the processor out of reset.

In normal running the block watches processor reads. A read of the recorded identifier address, or of the byte after it, returns one byte of a fixed replacement identifier instead of the ROM contents. Every other read passes the ROM byte through unchanged. A disable input skips the whole preboot phase, so a ROM without the marker boots as it is. The same holds for a ROM whose scan finds nothing. A 3-bit selector provides the upper flash address bits and so picks one of eight ROM images.

Top module: `rom_sig_patch`

## Requirements
- R1: From the release of `rst_n` until the end of the preboot phase, `bus_own` is 1 and `cpu_rst_n` is 0. While `bus_own` is 1, the low `IMG_AW` bits of `rom_addr` are the scan address.
- R2: The scan starts at image offset 0 and moves up by one address per clock. After the Nth rising clock edge that follows the release of `rst_n`, the scan address is N-1.
- R3: A match needs seven consecutive image bytes equal to EC, 9F, any, any, 83, 12, 34 in ascending address order. The scan stops at the first match. If the last byte (0x34) of that match is at offset e, then `bus_own` falls after rising edge e+2.
- R4: The pointer is the first wildcard byte times 256 plus the second wildcard byte. In run mode, a read (`cpu_rd`=1) with `cpu_addr` equal to the pointer returns SUB_ID[15:8]. A read at pointer+1 (modulo 2^16) returns SUB_ID[7:0].
- R5: `bus_own` goes low exactly one clock before `cpu_rst_n` goes high. After that, `bus_own` stays 0 and `cpu_rst_n` stays 1 until the next reset.
- R6: When `scan_dis` is 1 at reset release, no scan takes place. `bus_own` falls after the first edge and `cpu_rst_n` rises after the second. No read is substituted.
- R7: Without a match, the whole image is read. `bus_own` falls after edge 2^IMG_AW+1, and no read is substituted.
- R8: The upper 3 bits of `rom_addr` always equal `img_sel`. Once the bus is handed back, the low bits of `rom_addr` equal `cpu_rom_addr`.
- R9: In run mode, reads at any other address, and cycles with `cpu_rd`=0, return `rom_data` unchanged on `cpu_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| scan_dis | input | 1 | 1 skips the scan and the substitution |
| img_sel | input | SEL_W | Flash image selector (upper ROM address bits) |
| cpu_addr | input | CPU_AW | Processor logical address, compared with the pointer |
| cpu_rom_addr | input | IMG_AW | Paged ROM offset from the processor side |
| cpu_rd | input | 1 | Processor read strobe |
| rom_data | input | 8 | Byte returned by the flash |
| rom_addr | output | SEL_W+IMG_AW | Flash address |
| cpu_data | output | 8 | Byte returned to the processor |
| cpu_rst_n | output | 1 | Processor reset, active low |
| bus_own | output | 1 | 1 while the block drives the ROM address |

## Verification
The bench places markers at offset 0 and at the very end of an image. It also places one right after a false start (EC EC 9F ...), two markers in one image, and a marker only in an image that is not selected. A design that compared the wildcard bytes, that lost the first byte or the last byte of the image, or that read past its own image would find the wrong pointer or report a match at the wrong cycle. It measures the exact cycles at which `bus_own` falls and `cpu_rst_n` rises, which catches an off-by-one in the scan counter and a reversed handoff. Reads at the pointer, at pointer+1, at the addresses on either side, and with the read strobe low are mixed with random reads. This exposes a wrong byte order, a pointer taken from the wrong bytes, and a substitution left active after a disable or a failed scan.

// File: rtl/rom_sig_patch.sv
module rom_sig_patch #(
  parameter int IMG_AW = 19,
  parameter int SEL_W = 3,
  parameter int CPU_AW = 16,
  parameter logic [15:0] SUB_ID = 16'h0A5C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scan_dis,
  input  logic [SEL_W-1:0]        img_sel,
  input  logic [CPU_AW-1:0]       cpu_addr,
  input  logic [IMG_AW-1:0]       cpu_rom_addr,
  input  logic                    cpu_rd,
  input  logic [7:0]              rom_data,
  output logic [SEL_W+IMG_AW-1:0] rom_addr,
  output logic [7:0]              cpu_data,
  output logic                    cpu_rst_n,
  output logic                    bus_own
);
  localparam logic [IMG_AW-1:0] LAST = '1;

  typedef enum logic [1:0] {ST_START, ST_SCAN, ST_GIVE, ST_RUN} st_t;

  st_t               st;
  logic [IMG_AW-1:0] scan_addr;
  logic [47:0]       sh;
  logic [CPU_AW-1:0] ptr;
  logic              found;
  logic              hit;
  logic              hit_hi, hit_lo;

  assign hit = sh[47:40] == 8'hEC && sh[39:32] == 8'h9F && sh[15:8] == 8'h83 &&
               sh[7:0] == 8'h12 && rom_data == 8'h34;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_START;
      scan_addr <= '0;
      sh        <= '0;
      ptr       <= '0;
      found     <= 1'b0;
    end else begin
      case (st)
        ST_START: st <= scan_dis ? ST_GIVE : ST_SCAN;
        ST_SCAN: begin
          sh        <= {sh[39:0], rom_data};
          scan_addr <= scan_addr + 1'b1;
          if (hit) begin
            found <= 1'b1;
            ptr   <= CPU_AW'({sh[31:24], sh[23:16]});
            st    <= ST_GIVE;
          end else if (scan_addr == LAST) begin
            st <= ST_GIVE;
          end
        end
        ST_GIVE: st <= ST_RUN;
        default: st <= ST_RUN;
      endcase
    end
  end

  assign bus_own   = (st == ST_START) || (st == ST_SCAN);
  assign cpu_rst_n = (st == ST_RUN);
  assign rom_addr  = {img_sel, bus_own ? scan_addr : cpu_rom_addr};

  assign hit_hi = cpu_rst_n && found && cpu_rd && cpu_addr == ptr;
  assign hit_lo = cpu_rst_n && found && cpu_rd && cpu_addr == ptr + 1'b1;

  assign cpu_data = hit_hi ? SUB_ID[15:8] : hit_lo ? SUB_ID[7:0] : rom_data;
endmodule

module rom_sig_patch_chk #(
  parameter int ROM_AW = 22,
  parameter int SEL_W = 3,
  parameter logic [15:0] SUB_ID = 16'h0A5C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  img_sel,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              bus_own,
  input logic              cpu_rst_n,
  input logic              cpu_rd,
  input logic [7:0]        cpu_data,
  input logic [7:0]        rom_data
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> !cpu_rst_n);

  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(!bus_own) && $past(!cpu_rst_n));

  p_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |=> cpu_rst_n && !bus_own);

  p_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[ROM_AW-1 -: SEL_W] == img_sel);

  p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_data != rom_data) |->
      cpu_rst_n && cpu_rd && (cpu_data == SUB_ID[15:8] || cpu_data == SUB_ID[7:0]));
endmodule

bind rom_sig_patch rom_sig_patch_chk #(
  .ROM_AW(SEL_W + IMG_AW), .SEL_W(SEL_W), .SUB_ID(SUB_ID)
) chk_i (
  .clk(clk), .rst_n(rst_n), .img_sel(img_sel), .rom_addr(rom_addr),
  .bus_own(bus_own), .cpu_rst_n(cpu_rst_n), .cpu_rd(cpu_rd),
  .cpu_data(cpu_data), .rom_data(rom_data)
);

// File: tb/rom_sig_patch_tb_top.sv
module rom_sig_patch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IMG_AW = 9;
  localparam int IMG = 1 << IMG_AW;
  localparam int NB = 8 * IMG;
  localparam logic [15:0] SUB_ID = 16'h0A5C;

  logic clk = 0, rst_n = 0, scan_dis = 0, cpu_rd = 0;
  logic [2:0] img_sel = 0;
  logic [15:0] cpu_addr = 0;
  logic [IMG_AW-1:0] cpu_rom_addr = 0;
  logic [7:0] rom_data, cpu_data;
  logic [IMG_AW+2:0] rom_addr;
  logic cpu_rst_n, bus_own;
  logic [7:0] mem [0:NB-1];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rom_data = mem[rom_addr];

  rom_sig_patch #(.IMG_AW(IMG_AW), .SUB_ID(SUB_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_dis(scan_dis), .img_sel(img_sel),
    .cpu_addr(cpu_addr), .cpu_rom_addr(cpu_rom_addr), .cpu_rd(cpu_rd),
    .rom_data(rom_data), .rom_addr(rom_addr), .cpu_data(cpu_data),
    .cpu_rst_n(cpu_rst_n), .bus_own(bus_own));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < NB; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      mem[i] = (b == 8'hEC) ? 8'h00 : b;
    end
  endtask

  task automatic plant(input int sel, input int off, input logic [15:0] p);
    int a;
    a = sel * IMG + off;
    mem[a] = 8'hEC; mem[a+1] = 8'h9F; mem[a+2] = p[15:8]; mem[a+3] = p[7:0];
    mem[a+4] = 8'h83; mem[a+5] = 8'h12; mem[a+6] = 8'h34;
  endtask

  function automatic bit find(input int sel, output int e, output logic [15:0] p);
    for (int i = 6; i < IMG; i++) begin
      int b;
      b = sel * IMG + i;
      if (mem[b-6] == 8'hEC && mem[b-5] == 8'h9F && mem[b-2] == 8'h83 &&
          mem[b-1] == 8'h12 && mem[b] == 8'h34) begin
        e = i; p = {mem[b-4], mem[b-3]};
        return 1;
      end
    end
    e = IMG - 1; p = 0;
    return 0;
  endfunction

  function automatic logic [7:0] exp_data(input bit sub, input logic [15:0] p, input int sel);
    if (sub && cpu_rd && cpu_addr == p) return SUB_ID[15:8];
    if (sub && cpu_rd && cpu_addr == p + 16'd1) return SUB_ID[7:0];
    return mem[sel * IMG + int'(cpu_rom_addr)];
  endfunction

  task automatic rd(input logic [15:0] a, input bit r, input bit sub,
                    input logic [15:0] p, input int sel, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_rom_addr = IMG_AW'($urandom);
    #1;
    chk(cpu_data === exp_data(sub, p, sel), tag, cpu_data, exp_data(sub, p, sel));
    chk(rom_addr === {3'(sel), cpu_rom_addr}, "R8 run addr", rom_addr, {3'(sel), cpu_rom_addr});
  endtask

  task automatic boot(input int sel, input bit dis);
    int e, n, t_own, t_rst, bad_sel, bad_adr;
    logic [15:0] p;
    bit f, sub;
    f = find(sel, e, p);
    sub = f && !dis;
    @(negedge clk);
    rst_n = 0; img_sel = 3'(sel); scan_dis = dis; cpu_rd = 0;
    @(negedge clk);
    #1;
    chk(bus_own === 1 && cpu_rst_n === 0, "R1 reset state", {bus_own, cpu_rst_n}, 2);
    @(negedge clk);
    rst_n = 1;
    t_own = -1; t_rst = -1; bad_sel = 0; bad_adr = 0;
    for (n = 1; n < IMG + 20 && t_rst < 0; n++) begin
      @(posedge clk); #1;
      if (rom_addr[IMG_AW+2 -: 3] != 3'(sel)) bad_sel++;
      if (bus_own && !dis && int'(rom_addr[IMG_AW-1:0]) != n - 1) bad_adr++;
      if (bus_own && cpu_rst_n) bad_sel++;
      if (!bus_own && t_own < 0) t_own = n;
      if (cpu_rst_n && t_rst < 0) t_rst = n;
    end
    chk(bad_sel == 0, "R1/R8 upper bits and hold", bad_sel, 0);
    chk(bad_adr == 0, "R2 ascending scan address", bad_adr, 0);
    if (dis) begin
      chk(t_own == 1, "R6 handoff cycle", t_own, 1);
    end else if (f) begin
      chk(t_own == e + 2, "R3 stop cycle", t_own, e + 2);
    end else begin
      chk(t_own == IMG + 1, "R7 full scan cycle", t_own, IMG + 1);
    end
    chk(t_rst == t_own + 1, "R5 release order", t_rst, t_own + 1);
    rd(p, 1, sub, p, sel, "R4 high byte");
    rd(p + 16'd1, 1, sub, p, sel, "R4 low byte");
    rd(p - 16'd1, 1, sub, p, sel, "R9 below pointer");
    rd(p + 16'd2, 1, sub, p, sel, "R9 above pointer");
    rd(p, 0, sub, p, sel, "R9 no strobe");
    for (int k = 0; k < 20; k++)
      rd(16'($urandom), 1'($urandom), sub, p, sel, "R9 random read");
    @(negedge clk);
    chk(bus_own === 0 && cpu_rst_n === 1, "R5 stays released", {bus_own, cpu_rst_n}, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    fill();
    plant(2, 0, 16'h3FA1);
    boot(2, 0);
    fill();
    plant(5, IMG - 7, 16'hFFFF);
    boot(5, 0);
    fill();
    boot(1, 0);
    fill();
    plant(3, 40, 16'h1234);
    boot(3, 1);
    fill();
    plant(0, 100, 16'hBEEF);
    plant(0, 300, 16'h5555);
    boot(0, 0);
    fill();
    mem[7 * IMG + 50] = 8'hEC;
    plant(7, 51, 16'h00C3);
    boot(7, 0);
    fill();
    plant(4, 10, 16'h7777);
    boot(6, 0);
    for (int r = 0; r < 3; r++) begin
      int s;
      s = int'($urandom_range(7, 0));
      fill();
      plant(s, int'($urandom_range(IMG - 7, 0)), 16'($urandom));
      boot(s, 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule